// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block provides the timing for an asynchronous serial controller. Software writes one configuration byte. A two-bit prescale field and a three-bit rate field in that byte set how many bus-clock cycles make up one bit time. The prescale field picks a base divide of 1, 3, 4 or 13. That value is scaled by a fixed oversampling factor and then by a power of two set by the rate field. Counting runs on the bus clock divided by a fixed pre-divide. The block emits a one-cycle `bit_tick` at the end of every bit time. It also emits a one-cycle `frame_tick` at the end of every character, where a character lasts 10 or 11 bit times as chosen by `long_frame`.

Both ticks stop while the receiver enable and the transmitter enable are both low. When either enable goes high, counting starts again from zero. A write to the configuration byte restarts all counters at once, so the new rate applies from the write onward and no tick from the old rate escapes. The shifters and status flags that consume these ticks are in other blocks.

Top module: `baud_divider`

## Requirements
- R1: Synchronous active-low reset clears the configuration to zero. The first bit time after enabling is then OVS*CLK_DIV cycles, and no tick occurs while both enables are low after reset.
- R2: Configuration bits [5:4] select the base divide: 00 gives 1, 01 gives 3, 10 gives 4, 11 gives 13.
- R3: Configuration bits [2:0] hold a value n that multiplies the bit time by 2^n.
- R4: In steady running, consecutive `bit_tick` pulses are exactly CLK_DIV*OVS*base*2^n clock cycles apart, and each pulse lasts one cycle.
- R5: With `long_frame`=0, `frame_tick` coincides with every 10th `bit_tick`. With `long_frame`=1, it coincides with every 11th. The frame time is therefore the frame length times the bit time.
- R6: A clock edge that samples `rx_en` and `tx_en` both low stops all ticks from the following cycle on.
- R7: The clock edge that samples `cfg_wr` high loads `cfg_byte` and restarts the counters. The first `bit_tick` after that edge comes in the P-th cycle after it, where P is the new bit time.
- R8: Configuration bits 7, 6 and 3 are ignored and have no effect on the bit time.
- R9: Either enable alone keeps the ticks running. The first `bit_tick` comes in the P-th cycle after the edge that first samples an enable high.
- R10: The bit counter never reaches or passes the selected divisor. It is sized to hold the largest divisor, 13*OVS*128, which is 26624 at the default settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_byte | input | 8 | Configuration data: [5:4] prescale, [2:0] rate |
| long_frame | input | 1 | 0 selects 10-bit characters, 1 selects 11-bit characters |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit time |
| frame_tick | output | 1 | One-cycle pulse at the end of each character |

## Verification
The bench builds the block with OVS=1 and CLK_DIV=2. This keeps the longest bit time at 3328 cycles instead of 106496, so all 32 prescale and rate combinations can be measured twice each within the run. The pre-divide is still 2, so the prescaler stays in the path and each period reflects both stages. With these settings the reset divisor gives a 2-cycle bit time. Frames at both lengths, a write in the middle of a long period, and restarts by a single enable each take only a few hundred cycles.

// File: rtl/baud_div_pkg.sv
// Package: baud_div_pkg
// Shared encodings and helpers for the bit-rate tick generator.
// Assumes the configuration byte layout: [5:4] prescale, [2:0] rate.
package baud_div_pkg;

    // Prescale field encodings and their base divides
    typedef enum logic [1:0] {
        PRE_DIV1  = 2'b00,
        PRE_DIV3  = 2'b01,
        PRE_DIV4  = 2'b10,
        PRE_DIV13 = 2'b11
    } prescale_e;

    // Stored configuration: only the fields that matter
    typedef struct packed {
        prescale_e  prescale;
        logic [2:0] rate;
    } baud_cfg_t;

    localparam int unsigned SHORT_FRAME_BITS = 10;
    localparam int unsigned LONG_FRAME_BITS  = 11;
    localparam int unsigned MAX_BASE_DIV     = 13;
    localparam int unsigned MAX_RATE_SHIFT   = 7;

    // Map a prescale code to its base divide
    function automatic int unsigned base_divide(prescale_e sel);
        case (sel)
            PRE_DIV1:  return 1;
            PRE_DIV3:  return 3;
            PRE_DIV4:  return 4;
            default:   return 13;
        endcase
    endfunction

endpackage

// File: rtl/baud_decode.sv
// Module: baud_decode
// Converts the stored configuration into a bit time counted in
// pre-divided ticks: base * OVS * 2^rate.
// Assumes CNT_W is wide enough for 13 * OVS * 128.
module baud_decode
    import baud_div_pkg::*;
#(
    parameter int unsigned OVS   = 16,
    parameter int unsigned CNT_W = 16
) (
    input  baud_cfg_t          cfg,
    output logic [CNT_W-1:0]   period_ticks
);

    logic [31:0] scaled;

    // Multiply base divide by oversampling factor, then shift by rate
    always_comb begin
        scaled       = (32'(base_divide(cfg.prescale)) * 32'(OVS)) << cfg.rate;
        period_ticks = scaled[CNT_W-1:0];
    end

endmodule

// File: rtl/tick_prescaler.sv
// Module: tick_prescaler
// Divides the bus clock by CLK_DIV to form the counting enable.
// Assumes CLK_DIV >= 1; with CLK_DIV = 1 the enable is always high.
module tick_prescaler #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic count_en
);

    localparam int unsigned PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);

    logic [PW-1:0] cnt;

    // Free-running modulo-CLK_DIV counter, restarted by clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PW'(1);
        end
    end

    // Enable on the last phase of each pre-divide window
    assign count_en = (cnt == LAST);

endmodule

// File: rtl/bit_counter.sv
// Module: bit_counter
// Counts pre-divided ticks up to the bit time and flags its last tick.
// Assumes period_ticks >= 1 and only changes together with clear.
module bit_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic [CNT_W-1:0] period_ticks,
    output logic             bit_end
);

    logic [CNT_W-1:0] cnt;

    // End of bit: enabled tick while the count sits at period - 1
    assign bit_end = count_en && (cnt == (period_ticks - CNT_W'(1)));

    // Up-counter that wraps at the end of each bit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (count_en) begin
            cnt <= bit_end ? '0 : cnt + CNT_W'(1);
        end
    end

    // Counter stays strictly below the divisor chosen by the decoder
    assert_cnt_below_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period_ticks);

endmodule

// File: rtl/frame_counter.sv
// Module: frame_counter
// Counts bit ends and flags the last bit of each 10- or 11-bit frame.
// Assumes long_frame may change at any time; a shortened frame ends
// at the next bit end.
module frame_counter
    import baud_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_end,
    input  logic long_frame,
    output logic frame_end
);

    localparam int unsigned FW = $clog2(LONG_FRAME_BITS + 1);

    logic [FW-1:0] cnt;
    logic [FW-1:0] last_idx;

    // Index of the final bit for the selected length
    always_comb begin
        last_idx = long_frame ? FW'(LONG_FRAME_BITS - 1) : FW'(SHORT_FRAME_BITS - 1);
    end

    assign frame_end = bit_end && (cnt >= last_idx);

    // Bit index within the frame
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (bit_end) begin
            cnt <= frame_end ? '0 : cnt + FW'(1);
        end
    end

    // Bit index never exceeds the last bit of the longest frame
    assert_frame_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FW'(LONG_FRAME_BITS - 1));

endmodule

// File: rtl/baud_divider.sv
// Module: baud_divider
// Bit-rate and frame tick generator for an asynchronous serial port.
// Holds the configuration byte and runs prescaler, bit and frame
// counters. Assumes enables and strobe are synchronous to clk.
module baud_divider
    import baud_div_pkg::*;
#(
    parameter int unsigned OVS     = 16,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_byte,
    input  logic       long_frame,
    input  logic       rx_en,
    input  logic       tx_en,
    output logic       bit_tick,
    output logic       frame_tick
);

    localparam int unsigned MAX_DIV = MAX_BASE_DIV * OVS * (1 << MAX_RATE_SHIFT);
    localparam int unsigned CNT_W   = $clog2(MAX_DIV) + 1;
    localparam int unsigned MIN_P   = OVS * CLK_DIV;

    baud_cfg_t        cfg_q;
    logic             run_q;
    logic             clear_cnt;
    logic             count_en;
    logic             bit_end;
    logic             frame_end;
    logic [CNT_W-1:0] period_ticks;
    logic [2:0]       cfg_unused_bits;

    // Bits 7, 6 and 3 carry no function
    assign cfg_unused_bits = {cfg_byte[7:6], cfg_byte[3]};

    // Configuration register, loaded by the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{prescale: PRE_DIV1, rate: 3'd0};
        end else if (cfg_wr) begin
            cfg_q <= '{prescale: prescale_e'(cfg_byte[5:4]), rate: cfg_byte[2:0]};
        end
    end

    // Registered run flag: high while either enable was high last edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= rx_en | tx_en;
        end
    end

    // Counters restart while stopped and on every configuration write
    assign clear_cnt = !run_q || cfg_wr;

    baud_decode #(.OVS(OVS), .CNT_W(CNT_W)) u_decode (
        .cfg          (cfg_q),
        .period_ticks (period_ticks)
    );

    tick_prescaler #(.CLK_DIV(CLK_DIV)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_cnt),
        .count_en (count_en)
    );

    bit_counter #(.CNT_W(CNT_W)) u_bits (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear_cnt),
        .count_en     (count_en),
        .period_ticks (period_ticks),
        .bit_end      (bit_end)
    );

    frame_counter u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_cnt),
        .bit_end    (bit_tick),
        .long_frame (long_frame),
        .frame_end  (frame_end)
    );

    assign bit_tick   = run_q && bit_end;
    assign frame_tick = frame_end;

    // Both enables low: no tick in the following cycle
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en || tx_en) |=> (!bit_tick && !frame_tick));

    // A write restarts counting, so the next cycle carries no tick
    assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (MIN_P > 1)) |=> !bit_tick);

    // Bit ticks are single-cycle pulses when the bit time exceeds one cycle
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && (MIN_P > 1)) |=> !bit_tick);

    // A frame ends only on a bit end
    assert_frame_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> bit_end);

endmodule

// File: tb/baud_divider_test.sv
module baud_divider_test;

    localparam int OVS = 1;
    localparam int CD  = 2;
    localparam int LIM = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       long_frame = 1'b0;
    logic       rx_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       bit_tick;
    logic       frame_tick;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    baud_divider #(.OVS(OVS), .CLK_DIV(CD)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .long_frame(long_frame), .rx_en(rx_en), .tx_en(tx_en),
        .bit_tick(bit_tick), .frame_tick(frame_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int base_of(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 3;
            2'b10: return 4;
            default: return 13;
        endcase
    endfunction

    function automatic int period_of(input logic [7:0] b);
        return CD * OVS * base_of(b[5:4]) * (1 << b[2:0]);
    endfunction

    // Write strobe for one cycle; returns at the first negedge after the load edge
    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_byte = b;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Cycles from the current negedge (counted as 1) up to a bit tick
    task automatic cycles_to_tick(output int n);
        n = 1;
        while (!bit_tick && n < LIM) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Cycles and bit ticks from the current negedge up to a frame tick
    task automatic cycles_to_frame(output int n, output int bits);
        n = 1;
        bits = 0;
        while (n < 20 * LIM) begin
            if (bit_tick) bits++;
            if (frame_tick) break;
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int nb;
        int cnt;
        int p;
        logic [7:0] b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: disabled after reset, no ticks
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            if (bit_tick || frame_tick) cnt++;
        end
        check(cnt == 0, "R1 quiet after reset", cnt, 0);

        // R1: reset divisor gives OVS*CD cycles
        rx_en = 1'b1;
        @(negedge clk);
        cycles_to_tick(n);
        check(n == CD * OVS, "R1 reset bit time", n, CD * OVS);

        // R2 R3 R7 R4: sweep every prescale and rate
        for (int pre = 0; pre < 4; pre++) begin
            for (int rate = 0; rate < 8; rate++) begin
                b = {2'b00, 2'(pre), 1'b0, 3'(rate)};
                p = period_of(b);
                write_byte(b);
                cycles_to_tick(n);
                check(n == p, "R2 R3 R7 first tick after write", n, p);
                @(negedge clk);
                cycles_to_tick(n);
                check(n == p, "R4 steady bit spacing", n, p);
            end
        end

        // R8: spare bits set do not change the bit time
        write_byte(8'hDA);
        p = period_of(8'h12);
        cycles_to_tick(n);
        check(n == p, "R8 spare bits ignored", n, p);
        @(negedge clk);
        cycles_to_tick(n);
        check(n == p, "R8 spare bits ignored steady", n, p);

        // R5: short frame
        long_frame = 1'b0;
        write_byte(8'h01);
        p = period_of(8'h01);
        cycles_to_frame(n, nb);
        check(n == 10 * p, "R5 short frame time", n, 10 * p);
        check(nb == 10, "R5 short frame bit count", nb, 10);

        // R5: long frame, first and following
        long_frame = 1'b1;
        write_byte(8'h01);
        cycles_to_frame(n, nb);
        check(n == 11 * p, "R5 long frame time", n, 11 * p);
        check(nb == 11, "R5 long frame bit count", nb, 11);
        @(negedge clk);
        cycles_to_frame(n, nb);
        check(n == 11 * p, "R5 long frame repeat", n, 11 * p);
        long_frame = 1'b0;

        // R6: both enables low stops ticks
        write_byte(8'h03);
        p = period_of(8'h03);
        @(negedge clk);
        rx_en = 1'b0;
        tx_en = 1'b0;
        cnt = 0;
        repeat (300) begin
            @(negedge clk);
            if (bit_tick || frame_tick) cnt++;
        end
        check(cnt == 0, "R6 stopped while disabled", cnt, 0);

        // R9: transmitter enable alone restarts from zero
        tx_en = 1'b1;
        @(negedge clk);
        cycles_to_tick(n);
        check(n == p, "R9 tx enable alone", n, p);
        @(negedge clk);
        cycles_to_tick(n);
        check(n == p, "R9 tx enable alone steady", n, p);

        // R7: write in the middle of a long bit time
        write_byte(8'h37);
        repeat (100) @(negedge clk);
        write_byte(8'h00);
        cycles_to_tick(n);
        check(n == period_of(8'h00), "R7 mid-period reload", n, period_of(8'h00));

        // R10: longest divisor measured in full
        write_byte(8'h37);
        cycles_to_tick(n);
        check(n == period_of(8'h37), "R10 largest divisor", n, period_of(8'h37));

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule